// File: doc/BRIEF.md
# External Parallel Bus Master

This block drives an external memory-mapped bus. An internal requester issues one read or write with a 16-bit address. The block turns that request into pin-level activity on an 8-bit bidirectional data bus, with active-low write and read strobes. It can also drive an address-latch strobe, a high address byte, a low address byte on its own pins, and active-low chip selects. The block does not own the pads. For each pin group it supplies a value and an output enable, and arbitration logic outside the block decides which function reaches the pin.

Two address modes exist. In multiplexed mode the low address byte goes out on the data bus for one clock, and a latch strobe lets external logic capture it. In direct mode the low address byte is driven on a separate 8-pin group, and the latch strobe stays quiet. The high address byte and the chip selects each have their own enable. In direct mode a second active-low chip select carries the inverse of address bit 15.

Every access runs through four phases: address (1 clock), setup (1 clock), strobe (speed+1 clocks) and hold (1 clock). The requester sees a one-cycle acknowledge in the hold clock. Configuration inputs are expected to stay stable while an access is running.

Top module: `xbus_master`

## Requirements
- R1: After reset, every output enable is 0, `wr_n`, `rd_n`, `cs0_n` and `cs1_n` are 1, `ale` and `ack` are 0, and `addr_hi` is 0.
- R2: While `cfg_en` is 0, `req` is ignored: no acknowledge is given and both strobes stay high.
- R3: In multiplexed mode (`cfg_direct`=0), the first clock after acceptance has `ale`=1, `bus_d_oe`=1 and `bus_d_out` equal to address bits 7..0. `ale` is high for exactly that one clock.
- R4: In direct mode (`cfg_direct`=1), `ale` never rises, `addr_lo_oe` is 1, and `addr_lo` carries address bits 7..0. For a write, the data bus carries the write data from the first clock.
- R5: For a write, `wr_n` is low for exactly `cfg_speed`+1 consecutive clocks, starting on the third clock after acceptance. Throughout that window `bus_d_oe` is 1 and `bus_d_out` holds the write data.
- R6: For a read, `rd_n` is low for exactly `cfg_speed`+1 clocks with `bus_d_oe`=0 throughout. `rdata` takes the value of `bus_d_in` sampled on the last clock of that window.
- R7: `ack` is high for exactly one clock, the (4+`cfg_speed`)-th clock after acceptance (the acceptance edge ends clock 0).
- R8: `addr_hi_oe` equals `cfg_en` AND `cfg_hi_en`. During an access, `addr_hi` carries address bits 15..8.
- R9: With `cfg_cs_en`=1, `cs0_oe` is 1 and `cs0_n` is low on every clock of an access. `cs1_oe` is 1 only in direct mode, and during an access `cs1_n` equals the inverse of address bit 15.
- R10: `wr_n` and `rd_n` are never low at the same time. A request that arrives while an access is running is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Bus enable |
| cfg_direct | input | 1 | 1: direct low-address mode, 0: multiplexed mode |
| cfg_hi_en | input | 1 | High address byte output enable |
| cfg_cs_en | input | 1 | Chip select output enable |
| cfg_speed | input | 4 | Strobe width minus one, in clocks |
| req | input | 1 | Access request pulse, taken when idle |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid from ack |
| bus_d_out | output | 8 | Data bus drive value |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_d_in | input | 8 | Data bus pin value |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| strobe_oe | output | 1 | Output enable for the strobe pins |
| ale | output | 1 | Address latch strobe |
| addr_hi | output | 8 | Address bits 15..8 |
| addr_hi_oe | output | 1 | High address output enable |
| addr_lo | output | 8 | Address bits 7..0 (direct mode) |
| addr_lo_oe | output | 1 | Low address output enable |
| cs0_n | output | 1 | Chip select 0, active low |
| cs0_oe | output | 1 | Chip select 0 output enable |
| cs1_n | output | 1 | Inverted-A15 chip select, active low |
| cs1_oe | output | 1 | Chip select 1 output enable |

## Verification
The request is taken at a rising edge. That edge ends clock 0, and every later clock is numbered from it. The latch strobe and the address on the data bus appear in clock 1. The strobe window runs from clock 3 through clock 3+speed, and the acknowledge appears in clock 4+speed. Read data is captured at the edge that ends clock 3+speed. The bench samples every output at the falling edge of each numbered clock and counts low-strobe clocks against the speed setting. It drives `bus_d_in` with the true read value only during the last strobe clock, so a capture that is one clock early or late shows up as a wrong `rdata`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int SPD_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_SETUP  = 2'd2,
    PH_STROBE = 2'd3
  } phase_t;

  // Strobe-low width in clocks for a speed code.
  function automatic int unsigned strobe_clocks(input logic [SPD_W-1:0] spd);
    return int'(spd) + 1;
  endfunction
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW,
  parameter int SPEED_W = SPD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_direct,
  input  logic [SPEED_W-1:0] cfg_speed,
  input  logic               req,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [DATA_W-1:0]  bus_d_in,
  output logic               busy,
  output logic               in_addr,
  output logic               in_setup,
  output logic               in_strobe,
  output logic               in_hold,
  output logic               lat_we,
  output logic               lat_direct,
  output logic [ADDR_W-1:0]  lat_addr,
  output logic [DATA_W-1:0]  lat_wdata,
  output logic [DATA_W-1:0]  rdata
);
  phase_t             phase;
  logic               hold_q;
  logic [SPEED_W-1:0] cnt;
  logic               accept;
  logic               strobe_last;

  assign accept      = req && cfg_en && !busy;
  assign strobe_last = (phase == PH_STROBE) && (cnt == '0);
  assign in_addr     = (phase == PH_ADDR);
  assign in_setup    = (phase == PH_SETUP);
  assign in_strobe   = (phase == PH_STROBE);
  assign in_hold     = hold_q;
  assign busy        = (phase != PH_IDLE) || hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      hold_q     <= 1'b0;
      cnt        <= '0;
      lat_we     <= 1'b0;
      lat_direct <= 1'b0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      rdata      <= '0;
    end else begin
      hold_q <= strobe_last;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase      <= PH_ADDR;
          lat_we     <= req_we;
          lat_direct <= cfg_direct;
          lat_addr   <= req_addr;
          lat_wdata  <= req_wdata;
        end
        PH_ADDR:  phase <= PH_SETUP;
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= SPEED_W'(strobe_clocks(cfg_speed) - 1);
        end
        PH_STROBE: begin
          if (strobe_last) begin
            phase <= PH_IDLE;
            if (!lat_we) rdata <= bus_d_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Counter that measures the strobe window against its maximum.
  logic [SPEED_W:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_run <= '0;
    else if (in_strobe) strobe_run <= strobe_run + 1'b1;
    else strobe_run <= '0;
  end

  p_strobe_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |-> (strobe_run < (SPEED_W+1)'(1 << SPEED_W)));
  p_off_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_en) |=> !in_addr);
  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |=> !in_hold);
  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> $stable(lat_addr));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              cfg_en,
  input  logic              cfg_direct,
  input  logic              cfg_hi_en,
  input  logic              cfg_cs_en,
  input  logic              busy,
  input  logic              in_addr,
  input  logic              in_strobe,
  input  logic              lat_we,
  input  logic              lat_direct,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  output logic              wr_n,
  output logic              rd_n,
  output logic              strobe_oe,
  output logic              ale,
  output logic [DATA_W-1:0] addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] addr_lo,
  output logic              addr_lo_oe,
  output logic              cs0_n,
  output logic              cs0_oe,
  output logic              cs1_n,
  output logic              cs1_oe
);
  logic mux_addr;
  assign mux_addr = in_addr && !lat_direct;

  always_comb begin
    bus_d_out = mux_addr ? lat_addr[DATA_W-1:0] : lat_wdata;
    bus_d_oe  = busy && (mux_addr || lat_we);
  end

  assign wr_n       = !(in_strobe && lat_we);
  assign rd_n       = !(in_strobe && !lat_we);
  assign strobe_oe  = cfg_en;
  assign ale        = mux_addr;
  assign addr_hi    = lat_addr[ADDR_W-1 -: DATA_W];
  assign addr_hi_oe = cfg_en && cfg_hi_en;
  assign addr_lo    = lat_addr[DATA_W-1:0];
  assign addr_lo_oe = cfg_en && cfg_direct;
  assign cs0_n      = !busy;
  assign cs0_oe     = cfg_en && cfg_cs_en;
  assign cs1_n      = busy ? !lat_addr[ADDR_W-1] : 1'b1;
  assign cs1_oe     = cfg_en && cfg_cs_en && cfg_direct;

  always_comb begin
    a_strobe_excl_r10: assert (wr_n || rd_n);
    a_read_no_drive_r6: assert (rd_n || !bus_d_oe);
    a_ale_mux_only_r4: assert (!ale || !lat_direct);
  end
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = AW,
  parameter int DATA_W  = DW,
  parameter int SPEED_W = SPD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_direct,
  input  logic               cfg_hi_en,
  input  logic               cfg_cs_en,
  input  logic [SPEED_W-1:0] cfg_speed,
  input  logic               req,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               ack,
  output logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  bus_d_out,
  output logic               bus_d_oe,
  input  logic [DATA_W-1:0]  bus_d_in,
  output logic               wr_n,
  output logic               rd_n,
  output logic               strobe_oe,
  output logic               ale,
  output logic [DATA_W-1:0]  addr_hi,
  output logic               addr_hi_oe,
  output logic [DATA_W-1:0]  addr_lo,
  output logic               addr_lo_oe,
  output logic               cs0_n,
  output logic               cs0_oe,
  output logic               cs1_n,
  output logic               cs1_oe
);
  logic              busy, in_addr, in_setup, in_strobe, in_hold;
  logic              lat_we, lat_direct;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPEED_W(SPEED_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_direct(cfg_direct),
    .cfg_speed(cfg_speed), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_d_in(bus_d_in), .busy(busy),
    .in_addr(in_addr), .in_setup(in_setup), .in_strobe(in_strobe),
    .in_hold(in_hold), .lat_we(lat_we), .lat_direct(lat_direct),
    .lat_addr(lat_addr), .lat_wdata(lat_wdata), .rdata(rdata)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .cfg_en(cfg_en), .cfg_direct(cfg_direct), .cfg_hi_en(cfg_hi_en),
    .cfg_cs_en(cfg_cs_en), .busy(busy), .in_addr(in_addr),
    .in_strobe(in_strobe), .lat_we(lat_we), .lat_direct(lat_direct),
    .lat_addr(lat_addr), .lat_wdata(lat_wdata), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .wr_n(wr_n), .rd_n(rd_n), .strobe_oe(strobe_oe),
    .ale(ale), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .addr_lo(addr_lo), .addr_lo_oe(addr_lo_oe), .cs0_n(cs0_n),
    .cs0_oe(cs0_oe), .cs1_n(cs1_n), .cs1_oe(cs1_oe)
  );

  assign ack = in_hold;

  p_setup_before_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(in_setup));
  p_ack_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(in_strobe));
  p_ale_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
endmodule

// File: tb/xbus_master_test.sv
`timescale 1ns/1ps
module xbus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_direct = 1'b0, cfg_hi_en = 1'b0, cfg_cs_en = 1'b0;
  logic [3:0]  cfg_speed = '0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_d_in = '0;
  logic        ack, bus_d_oe, wr_n, rd_n, strobe_oe, ale;
  logic        addr_hi_oe, addr_lo_oe, cs0_n, cs0_oe, cs1_n, cs1_oe;
  logic [7:0]  rdata, bus_d_out, addr_hi, addr_lo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xbus_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_direct(cfg_direct),
    .cfg_hi_en(cfg_hi_en), .cfg_cs_en(cfg_cs_en), .cfg_speed(cfg_speed),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .bus_d_in(bus_d_in), .wr_n(wr_n), .rd_n(rd_n), .strobe_oe(strobe_oe),
    .ale(ale), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .addr_lo(addr_lo),
    .addr_lo_oe(addr_lo_oe), .cs0_n(cs0_n), .cs0_oe(cs0_oe), .cs1_n(cs1_n),
    .cs1_oe(cs1_oe)
  );

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  // {we, direct, speed[3:0], addr[15:0], wdata[7:0], rdin[7:0]}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0,  16'h1234, 8'hA5, 8'h00},
    {1'b0, 1'b0, 4'd2,  16'h8001, 8'h00, 8'h3C},
    {1'b1, 1'b1, 4'd3,  16'hFF80, 8'h5A, 8'h00},
    {1'b0, 1'b1, 4'd0,  16'h0077, 8'h00, 8'hC3},
    {1'b1, 1'b1, 4'd15, 16'h7F01, 8'h0F, 8'h00},
    {1'b0, 1'b0, 4'd15, 16'hABCD, 8'h00, 8'h96},
    {1'b0, 1'b1, 4'd7,  16'h8000, 8'h00, 8'hFF},
    {1'b1, 1'b0, 4'd1,  16'h00FE, 8'h00, 8'h00}
  };

  task automatic run_xfer(input logic we, input logic dir, input logic [3:0] spd,
                          input logic [15:0] addr, input logic [7:0] wd,
                          input logic [7:0] rdin, input logic extra_req);
    int ale_n = 0, str_n = 0, ack_n = 0, ack_at = -1, first_str = -1;
    int both_low = 0, rd_drive = 0, wbad = 0, cs_bad = 0, hi_bad = 0;
    @(negedge clk);
    cfg_direct = dir; cfg_speed = spd;
    req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    bus_d_in = ~rdin;
    for (int c = 1; c <= int'(spd) + 7; c++) begin
      @(negedge clk);
      req = extra_req && (c == 2);
      if (c == 2) req_addr = ~addr;
      if (c == 1) begin
        if (!dir) begin
          check("R3", "ale in addr clock", ale, 1);
          check("R3", "bus carries addr lo", {bus_d_oe, bus_d_out}, {1'b1, addr[7:0]});
        end else begin
          check("R4", "addr_lo pins", {addr_lo_oe, addr_lo}, {1'b1, addr[7:0]});
          if (we) check("R4", "wdata from first clock", {bus_d_oe, bus_d_out}, {1'b1, wd});
        end
      end
      if (ale) ale_n++;
      if (!wr_n && !rd_n) both_low++;
      if ((we ? wr_n : rd_n) == 1'b0) begin
        str_n++;
        if (first_str < 0) first_str = c;
        if (!we && bus_d_oe) rd_drive++;
        if (we && (!bus_d_oe || bus_d_out !== wd)) wbad++;
      end
      if ((we ? rd_n : wr_n) == 1'b0) str_n += 100;
      if (ack) begin ack_n++; ack_at = c; end
      if (c <= int'(spd) + 4) begin
        if (cs0_n !== 1'b0 || cs1_n !== ~addr[15]) cs_bad++;
        if (addr_hi !== addr[15:8]) hi_bad++;
      end
      bus_d_in = (c == int'(spd) + 3) ? rdin : ~rdin;
    end
    check("R3", "ale clock count", ale_n, dir ? 0 : 1);
    check("R4", "ale silent in direct", (dir && ale_n != 0), 0);
    check(we ? "R5" : "R6", "strobe width", str_n, int'(spd) + 1);
    check(we ? "R5" : "R6", "strobe start clock", first_str, 3);
    check("R7", "ack count", ack_n, 1);
    check("R7", "ack clock", ack_at, int'(spd) + 4);
    check("R10", "strobes never both low", both_low, 0);
    check("R8", "addr_hi during access", hi_bad, 0);
    check("R9", "chip selects during access", cs_bad, 0);
    check("R9", "cs1_oe per mode", cs1_oe, dir);
    if (we) check("R5", "write data held in strobe", wbad, 0);
    else begin
      check("R6", "no drive while reading", rd_drive, 0);
      check("R6", "read data", rdata, rdin);
    end
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "enables after reset",
          {bus_d_oe, strobe_oe, addr_hi_oe, addr_lo_oe, cs0_oe, cs1_oe}, 0);
    check("R1", "strobes and cs idle", {wr_n, rd_n, cs0_n, cs1_n, ale, ack}, 6'b111100);
    check("R1", "addr_hi reset", addr_hi, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: disabled bus ignores requests
    begin
      int act = 0;
      req = 1'b1; req_we = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (ack || !wr_n || !rd_n) act++;
      end
      req = 1'b0;
      check("R2", "no activity while disabled", act, 0);
    end
    cfg_en = 1'b1; cfg_hi_en = 1'b1; cfg_cs_en = 1'b1;
    @(negedge clk);
    check("R8", "addr_hi_oe enabled", addr_hi_oe, 1);
    check("R9", "cs0_oe enabled", cs0_oe, 1);
    for (int v = 0; v < NV; v++)
      run_xfer(VEC[v][37], VEC[v][36], VEC[v][35:32], VEC[v][31:16],
               VEC[v][15:8], VEC[v][7:0], 1'b0);
    // R10: request during busy is dropped (only one ack, original address)
    run_xfer(1'b1, 1'b1, 4'd2, 16'h4321, 8'h11, 8'h00, 1'b1);
    repeat (8) @(negedge clk);
    check("R10", "no second access", {ack, wr_n, rd_n}, 3'b011);
    cfg_hi_en = 1'b0; cfg_cs_en = 1'b0;
    @(negedge clk);
    check("R8", "addr_hi_oe off", addr_hi_oe, 0);
    check("R9", "cs oe off", {cs0_oe, cs1_oe}, 0);
    cfg_en = 1'b0;
    @(negedge clk);
    check("R1", "strobe_oe off when disabled", strobe_oe, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule